// File: doc/BRIEF.md
# Digital Potentiometer Serial Command Decoder

This block is the command front end of a single-wiper, 256-step digital potentiometer. It is an SPI mode-0 slave. It samples chip select, serial clock and serial data on its own system clock, and it decodes a frame that always opens with a two-byte header. The first byte carries a fixed device-type nibble, two zero bits and a two-bit device address. The address must equal the strap pins, or the frame is dropped. The second byte carries a 4-bit opcode, a 2-bit register select and a 2-bit bank select.

Eight commands follow from the opcode:
- Read or write of the wiper position, with a data byte.
- Read or write of one of sixteen data registers, with a data byte.
- Transfer from a data register to the wiper, or from the wiper to a data register. Both are complete after the header.
- A status read. Its data byte reports whether a simulated nonvolatile save is still running.
- An open-ended increment/decrement mode. In this mode each serial clock moves the wiper one step up or down.

Read data leaves on a serial output with its own output enable. The output enable is high only while a read byte is being shifted out. The wiper position is a port and drives the resistor array outside this block.

Top module: `dpot_spi_top`

## Requirements
- R1: The first header byte must be 0101 in bits 7:4, 00 in bits 3:2 and the strap value in bits 1:0, sent MSB first. Any mismatch makes the block ignore the frame until chip select rises.
- R2: The second header byte is opcode in bits 7:4, register select {RB,RA} in bits 3:2 and bank {P1,P0} in bits 1:0. The data-register commands (write 1100, read 1011) accept every bank. The register index is {P1,P0,RB,RA}, which gives 16 independent 8-bit registers.
- R3: Write wiper (1010) loads the third byte into the wiper. Read wiper (1001) returns it. Both act only when bank = 00. With any other bank the frame is ignored.
- R4: The transfer commands data-register-to-wiper (1101) and wiper-to-data-register (1110) need bank = 00. They use register index {00,RB,RA}, carry no data byte and take effect at the 16th bit.
- R5: Increment/decrement (0010, bank 00) moves the wiper one step per clock after the header: up when the data bit is 1, down when it is 0. The wiper saturates at 255 and at 0.
- R6: Read status (0101, any bank) returns a byte whose bit 0 is 1 for BUSY_CYCLES clocks after any data-register update. The other bits are 0.
- R7: The serial output changes on falling serial clock. The MSB of a read byte is valid after the falling edge that follows the 16th rising edge. The output enable is low outside the 8 read-data bits and whenever chip select is high.
- R8: If chip select rises before the last required bit of a command, no register changes.
- R9: An unlisted opcode makes the block ignore the frame, with no register change.
- R10: After reset the wiper holds WIPER_RESET (default 128), every data register holds 0 and the output enable is low.
- R11: Once a 2-byte or 3-byte command has completed, further clocks in the same frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data from host, sampled on rising serial clock |
| addr_strap | input | 2 | Strapped device address compared with header bits 1:0 |
| so | output | 1 | Serial read data, changes on falling serial clock |
| so_oe | output | 1 | Output enable for so, high only while read data is driven |
| wiper_pos | output | 8 | Current wiper position to the tap array |

## Verification
A wrong header decode or register index is visible at the port within a few system clocks of the deciding edge. It shows up either on wiper_pos or as a wrong byte in the next read frame, which is why the bench reads back every register it has touched. A stale saturation or busy counter shows in the first increment/decrement clock or status read that reaches the boundary. A shift-register slip corrupts the MSB of the very next read byte, and a leftover enable shows as so_oe high during a header or after deselect.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;
    localparam int NUM_DR = 1 << IDX_W;
    localparam logic [3:0] TYPE_ID = 4'b0101;

    localparam logic [3:0] OP_INCDEC = 4'b0010;
    localparam logic [3:0] OP_STATUS = 4'b0101;
    localparam logic [3:0] OP_RD_W   = 4'b1001;
    localparam logic [3:0] OP_WR_W   = 4'b1010;
    localparam logic [3:0] OP_RD_D   = 4'b1011;
    localparam logic [3:0] OP_WR_D   = 4'b1100;
    localparam logic [3:0] OP_X_DW   = 4'b1101;
    localparam logic [3:0] OP_X_WD   = 4'b1110;

    typedef enum logic [3:0] {
        CMD_BAD, CMD_RD_W, CMD_WR_W, CMD_RD_D, CMD_WR_D,
        CMD_X_DW, CMD_X_WD, CMD_INCDEC, CMD_STATUS
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_DIN, ST_DOUT, ST_INCDEC, ST_DONE, ST_IGNORE
    } state_e;

    typedef struct packed {
        logic [3:0] op;
        logic [1:0] reg_sel;
        logic [1:0] bank;
    } hdr2_t;

    function automatic logic hdr1_ok(input logic [7:0] b, input logic [1:0] strap);
        return (b[7:4] == TYPE_ID) && (b[3:2] == 2'b00) && (b[1:0] == strap);
    endfunction

    function automatic cmd_e decode(input hdr2_t h);
        logic b0;
        b0 = (h.bank == 2'b00);
        case (h.op)
            OP_RD_W:   return b0 ? CMD_RD_W   : CMD_BAD;
            OP_WR_W:   return b0 ? CMD_WR_W   : CMD_BAD;
            OP_RD_D:   return CMD_RD_D;
            OP_WR_D:   return CMD_WR_D;
            OP_X_DW:   return b0 ? CMD_X_DW   : CMD_BAD;
            OP_X_WD:   return b0 ? CMD_X_WD   : CMD_BAD;
            OP_INCDEC: return b0 ? CMD_INCDEC : CMD_BAD;
            OP_STATUS: return CMD_STATUS;
            default:   return CMD_BAD;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] full_index(input hdr2_t h);
        return {h.bank, h.reg_sel};
    endfunction

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[g];
                s2 <= RST_VAL[g];
            end else begin
                s1 <= din[g];
                s2 <= s1;
            end
        end
        assign lvl[g] = s2;
    end
endmodule

// File: rtl/dpot_edge.sv
module dpot_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;
    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= lvl;
    end
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
    import dpot_pkg::*;
#(
    parameter int WIPER_RESET = 128,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              dr_we,
    input  logic [IDX_W-1:0]  dr_widx,
    input  logic [BYTE_W-1:0] dr_wdata,
    input  logic              w_we,
    input  logic [BYTE_W-1:0] w_wdata,
    input  logic              inc,
    input  logic              dec,
    output logic [BYTE_W-1:0] wiper,
    output logic              busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [BYTE_W-1:0] W_MAX = '1;

    logic [BYTE_W-1:0] dr_q [NUM_DR];
    logic [CNT_W-1:0]  busy_cnt;

    for (genvar g = 0; g < NUM_DR; g++) begin : g_dr
        always_ff @(posedge clk) begin
            if (rst) dr_q[g] <= '0;
            else if (dr_we && dr_widx == IDX_W'(g)) dr_q[g] <= dr_wdata;
        end
    end

    assign rd_data = dr_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst)                busy_cnt <= '0;
        else if (dr_we)         busy_cnt <= CNT_W'(BUSY_CYCLES);
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1'b1;
    end
    assign busy = (busy_cnt != 0);

    always_ff @(posedge clk) begin
        if (rst)                      wiper <= BYTE_W'(WIPER_RESET);
        else if (w_we)                wiper <= w_wdata;
        else if (inc && wiper != W_MAX) wiper <= wiper + 1'b1;
        else if (dec && wiper != '0)  wiper <= wiper - 1'b1;
    end

    a_r5_ceiling: assert property (@(posedge clk) disable iff (rst)
        (inc && !w_we && wiper == W_MAX) |=> (wiper == W_MAX));
    a_r5_floor: assert property (@(posedge clk) disable iff (rst)
        (dec && !w_we && wiper == '0) |=> (wiper == '0));
    a_r6_busy_after_update: assert property (@(posedge clk) disable iff (rst)
        dr_we |=> busy);
    a_r3_wiper_hold: assert property (@(posedge clk) disable iff (rst)
        !(w_we || inc || dec) |=> $stable(wiper));
endmodule

// File: rtl/dpot_cmd.sv
module dpot_cmd
    import dpot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        strap,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              si,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] wiper,
    input  logic              busy,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              dr_we,
    output logic [IDX_W-1:0]  dr_widx,
    output logic [BYTE_W-1:0] dr_wdata,
    output logic              w_we,
    output logic [BYTE_W-1:0] w_wdata,
    output logic              inc,
    output logic              dec,
    output logic              so,
    output logic              so_oe
);
    state_e            state;
    cmd_e              cmd_q, cur_cmd;
    logic [3:0]        cnt;
    logic [6:0]        hdr_q;
    logic [6:0]        din_q;
    logic [BYTE_W-1:0] out_q;
    logic [IDX_W-1:0]  sel_idx;
    logic              drive;
    logic [7:0]        cur_byte;
    hdr2_t             h2;

    always_comb begin
        cur_byte = {hdr_q, si};
        h2       = hdr2_t'(cur_byte);
        cur_cmd  = decode(h2);
        rd_idx   = (cur_cmd == CMD_X_DW || cur_cmd == CMD_X_WD) ?
                   {2'b00, h2.reg_sel} : full_index(h2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cmd_q    <= CMD_BAD;
            cnt      <= '0;
            hdr_q    <= '0;
            din_q    <= '0;
            out_q    <= '0;
            sel_idx  <= '0;
            drive    <= 1'b0;
            dr_we    <= 1'b0;
            dr_widx  <= '0;
            dr_wdata <= '0;
            w_we     <= 1'b0;
            w_wdata  <= '0;
            inc      <= 1'b0;
            dec      <= 1'b0;
        end else begin
            dr_we <= 1'b0;
            w_we  <= 1'b0;
            inc   <= 1'b0;
            dec   <= 1'b0;
            if (cs_fall) begin
                state <= ST_HDR;
                cnt   <= '0;
                drive <= 1'b0;
            end else if (cs_rise) begin
                state <= ST_IDLE;
                drive <= 1'b0;
            end else if (sck_rise) begin
                case (state)
                    ST_HDR: begin
                        hdr_q <= cur_byte[6:0];
                        cnt   <= cnt + 1'b1;
                        if (cnt == 4'd7 && !hdr1_ok(cur_byte, strap)) begin
                            state <= ST_IGNORE;
                        end else if (cnt == 4'd15) begin
                            cnt     <= '0;
                            cmd_q   <= cur_cmd;
                            sel_idx <= rd_idx;
                            case (cur_cmd)
                                CMD_RD_W:   begin out_q <= wiper;   state <= ST_DOUT; end
                                CMD_RD_D:   begin out_q <= rd_data; state <= ST_DOUT; end
                                CMD_STATUS: begin out_q <= {7'b0, busy}; state <= ST_DOUT; end
                                CMD_WR_W, CMD_WR_D: state <= ST_DIN;
                                CMD_X_DW: begin
                                    w_we    <= 1'b1;
                                    w_wdata <= rd_data;
                                    state   <= ST_DONE;
                                end
                                CMD_X_WD: begin
                                    dr_we    <= 1'b1;
                                    dr_widx  <= rd_idx;
                                    dr_wdata <= wiper;
                                    state    <= ST_DONE;
                                end
                                CMD_INCDEC: state <= ST_INCDEC;
                                default:    state <= ST_IGNORE;
                            endcase
                        end
                    end
                    ST_DIN: begin
                        din_q <= {din_q[5:0], si};
                        cnt   <= cnt + 1'b1;
                        if (cnt == 4'd7) begin
                            state <= ST_DONE;
                            if (cmd_q == CMD_WR_D) begin
                                dr_we    <= 1'b1;
                                dr_widx  <= sel_idx;
                                dr_wdata <= {din_q, si};
                            end else begin
                                w_we    <= 1'b1;
                                w_wdata <= {din_q, si};
                            end
                        end
                    end
                    ST_DOUT: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == 4'd7) state <= ST_DONE;
                    end
                    ST_INCDEC: begin
                        if (si) inc <= 1'b1;
                        else    dec <= 1'b1;
                    end
                    default: ;
                endcase
            end else if (sck_fall && state == ST_DOUT) begin
                if (drive) out_q <= {out_q[6:0], 1'b0};
                else       drive <= 1'b1;
            end
        end
    end

    assign so    = out_q[7];
    assign so_oe = drive && (state == ST_DOUT);

    a_r7_so_hold: assert property (@(posedge clk) disable iff (rst)
        (so_oe && !sck_fall && !cs_fall) |=> (so == $past(so)));
    a_r8_no_update_after_deselect: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> !(dr_we || w_we || inc || dec));
    a_r11_done_is_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !cs_fall) |=> !(dr_we || w_we || inc || dec));
endmodule

// File: rtl/dpot_spi_top.sv
module dpot_spi_top
    import dpot_pkg::*;
#(
    parameter int WIPER_RESET = 128,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic [1:0]        addr_strap,
    output logic              so,
    output logic              so_oe,
    output logic [BYTE_W-1:0] wiper_pos
);
    logic [2:0] lvl;
    logic cs_rise, cs_fall, sck_rise, sck_fall;
    logic [IDX_W-1:0]  rd_idx, dr_widx;
    logic [BYTE_W-1:0] rd_data, dr_wdata, w_wdata;
    logic dr_we, w_we, inc, dec, busy;

    dpot_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst), .din({cs_n, sck, si}), .lvl(lvl));

    dpot_edge #(.RST_VAL(1'b1)) u_cs_edge (
        .clk(clk), .rst(rst), .lvl(lvl[2]), .rise(cs_rise), .fall(cs_fall));

    dpot_edge #(.RST_VAL(1'b0)) u_sck_edge (
        .clk(clk), .rst(rst), .lvl(lvl[1]), .rise(sck_rise), .fall(sck_fall));

    dpot_cmd u_cmd (
        .clk(clk), .rst(rst), .strap(addr_strap),
        .cs_rise(cs_rise), .cs_fall(cs_fall),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si(lvl[0]),
        .rd_data(rd_data), .wiper(wiper_pos), .busy(busy),
        .rd_idx(rd_idx), .dr_we(dr_we), .dr_widx(dr_widx), .dr_wdata(dr_wdata),
        .w_we(w_we), .w_wdata(w_wdata), .inc(inc), .dec(dec),
        .so(so), .so_oe(so_oe));

    dpot_regs #(.WIPER_RESET(WIPER_RESET), .BUSY_CYCLES(BUSY_CYCLES)) u_regs (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
        .dr_we(dr_we), .dr_widx(dr_widx), .dr_wdata(dr_wdata),
        .w_we(w_we), .w_wdata(w_wdata), .inc(inc), .dec(dec),
        .wiper(wiper_pos), .busy(busy));

    a_r7_release_on_deselect: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> !so_oe);
    a_r7_oe_only_while_selected: assert property (@(posedge clk) disable iff (rst)
        so_oe |-> !lvl[2]);
endmodule

// File: tb/dpot_spi_top_test.sv
module dpot_spi_top_test;
    localparam int HALF = 8;
    localparam int NV   = 26;

    // {frame bytes, bit count, is_read, expected read byte}
    localparam logic [37:0] VECS [NV] = '{
        {24'h52A03C, 5'd24, 1'b0, 8'h00},  // R3 write wiper
        {24'h529000, 5'd24, 1'b1, 8'h3C},  // R3 read wiper
        {24'h52CDA5, 5'd24, 1'b0, 8'h00},  // R2 write idx 7
        {24'h52BD00, 5'd24, 1'b1, 8'hA5},  // R2 read idx 7
        {24'h52CE3E, 5'd24, 1'b0, 8'h00},  // R2 write idx 11
        {24'h52BE00, 5'd24, 1'b1, 8'h3E},  // R2 read idx 11
        {24'h52BD00, 5'd24, 1'b1, 8'hA5},  // R2 idx 7 untouched
        {24'h52C85A, 5'd24, 1'b0, 8'h00},  // R2 write idx 2
        {24'h52D800, 5'd16, 1'b0, 8'h00},  // R4 DR2 -> wiper
        {24'h529000, 5'd24, 1'b1, 8'h5A},  // R4 check
        {24'h52A011, 5'd24, 1'b0, 8'h00},  // R3 wiper 11
        {24'h52E400, 5'd16, 1'b0, 8'h00},  // R4 wiper -> DR1
        {24'h52B400, 5'd24, 1'b1, 8'h11},  // R4 check DR1
        {24'h51A0FF, 5'd24, 1'b0, 8'h00},  // R1 wrong address
        {24'h62A0EE, 5'd24, 1'b0, 8'h00},  // R1 wrong type
        {24'h56A0DD, 5'd24, 1'b0, 8'h00},  // R1 nonzero pad bits
        {24'h529000, 5'd24, 1'b1, 8'h11},  // R1 check
        {24'h52A1CC, 5'd24, 1'b0, 8'h00},  // R3 bank 01 ignored
        {24'h52F0BB, 5'd24, 1'b0, 8'h00},  // R9 opcode 1111
        {24'h5200BB, 5'd24, 1'b0, 8'h00},  // R9 opcode 0000
        {24'h529000, 5'd24, 1'b1, 8'h11},  // R3 R9 check
        {24'h52A0AA, 5'd20, 1'b0, 8'h00},  // R8 abort wiper write
        {24'h529000, 5'd24, 1'b1, 8'h11},  // R8 check
        {24'h52CD77, 5'd23, 1'b0, 8'h00},  // R8 abort DR write
        {24'h52BD00, 5'd24, 1'b1, 8'hA5},  // R8 check
        {24'h52BF00, 5'd24, 1'b1, 8'h00}   // R10 untouched DR reset value
    };

    logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic [1:0] strap = 2'b10;
    logic so, so_oe;
    logic [7:0] wiper_pos;
    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dpot_spi_top uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .addr_strap(strap), .so(so), .so_oe(so_oe), .wiper_pos(wiper_pos));

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Sends nb bits MSB first; bits 16..23 are captured as read data.
    task automatic frame(input logic [31:0] f, input int nb, output logic [7:0] rd,
                         output logic oe_rd_all, output logic oe_rd_any,
                         output logic oe_other);
        logic s_so, s_oe;
        rd = '0; oe_rd_all = 1'b1; oe_rd_any = 1'b0; oe_other = 1'b0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nb; i++) begin
            si = f[31-i];
            wait_clk(HALF);
            s_so = so; s_oe = so_oe;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
            if (i >= 16 && i < 24) begin
                rd = {rd[6:0], s_so};
                oe_rd_all &= s_oe;
                oe_rd_any |= s_oe;
            end else begin
                oe_other |= s_oe;
            end
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2*HALF);
    endtask

    logic [7:0] rd;
    logic oa, oy, oo;

    initial begin
        wait_clk(150000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        chk("R10 wiper reset", wiper_pos, 8'h80);
        chk("R10 so_oe reset", {7'b0, so_oe}, 8'h00);

        for (int v = 0; v < NV; v++) begin
            frame({VECS[v][37:14], 8'h00}, int'(VECS[v][13:9]), rd, oa, oy, oo);
            if (VECS[v][8]) begin
                chk($sformatf("R2/R3/R4 vector %0d read data", v), rd, VECS[v][7:0]);
                chk($sformatf("R7 vector %0d oe during read", v), {7'b0, oa & ~oo}, 8'h01);
            end else begin
                chk($sformatf("R7 vector %0d oe idle in write", v), {6'b0, oy, oo}, 8'h00);
            end
        end
        chk("R3 R8 wiper port after table", wiper_pos, 8'h11);
        chk("R7 so_oe with cs high", {7'b0, so_oe}, 8'h00);

        // R11: trailing byte after a complete write is ignored
        frame({24'h52A044, 8'h99}, 32, rd, oa, oy, oo);
        chk("R11 extra bits ignored", wiper_pos, 8'h44);

        // R5: saturation at top, then steps down
        frame({24'h52A0FE, 8'h00}, 24, rd, oa, oy, oo);
        frame({16'h5220, 5'b11100, 11'h0}, 21, rd, oa, oy, oo);
        chk("R5 inc saturate then dec", wiper_pos, 8'hFD);
        frame({24'h52A001, 8'h00}, 24, rd, oa, oy, oo);
        frame({16'h5220, 16'h0000}, 19, rd, oa, oy, oo);
        chk("R5 dec saturate at zero", wiper_pos, 8'h00);
        frame({16'h5221, 16'hE000}, 19, rd, oa, oy, oo);
        chk("R5 incdec bank 01 ignored", wiper_pos, 8'h00);

        // R6: busy after a data register write, then clear
        frame({24'h52CC42, 8'h00}, 24, rd, oa, oy, oo);
        frame({24'h525000, 8'h00}, 24, rd, oa, oy, oo);
        chk("R6 status busy", rd, 8'h01);
        wait_clk(1200);
        frame({24'h525000, 8'h00}, 24, rd, oa, oy, oo);
        chk("R6 status idle", rd, 8'h00);
        frame({24'h52B000 | 24'h000C00, 8'h00}, 24, rd, oa, oy, oo);
        chk("R2 read idx 3", rd, 8'h42);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        finished = 1'b1;
        $finish;
    end
endmodule